// File: doc/BRIEF.md
# Interrupt and Video-Timing Status Register Block

This block is the read side of a CPU's status register space. It assembles byte-wide status words from two sticky interrupt flags, the horizontal and vertical position counters, the display height, an auto-poll busy flag and the serial data lines of a second controller port. Any bit of those words that has no function takes its value from a bus latch. The bus latch holds the last byte seen on the data bus, whether that byte was written or read back.

The block also holds one general-purpose output register. Writing it so that bit 7 goes from 1 to 0 emits a one-cycle pulse, which asks the video side to capture its position counters. The counters, the flag set strobes and the poll status arrive as inputs.

Register selection uses a 3-bit index:

| Index | Register |
|-------|----------|
| 0 | NMI status |
| 1 | IRQ status |
| 2 | blanking status |
| 3 | output register |
| 4 | port-2 status |
| 5 to 7 | unmapped |

Top module: `irq_video_status`

## Requirements
- R1: A read of index 0 returns the NMI flag in bit 7, bus-latch bits 6..4 in bits 6..4, and the 4-bit parameter CHIP_VER in bits 3..0.
- R2: A read of index 1 returns the IRQ flag in bit 7 and bus-latch bits 6..0 in bits 6..0.
- R3: A one-cycle pulse on `nmi_set` or `irq_set` sets its flag, and the flag stays set until its status register is read. That read returns the flag and then clears it. A set that arrives in the same cycle as the read leaves the flag set. Reading one flag's register does not change the other flag.
- R4: In a read of index 2, bit 7 is 1 when `vpos` is greater than or equal to `disp_height`, and 0 otherwise.
- R5: In a read of index 2, bit 6 is 1 when `hpos` is at most 2 or at least 1096, and 0 otherwise.
- R6: In a read of index 2, bit 0 equals `poll_busy` and bits 5..1 come from the bus latch.
- R7: A read of index 4 returns 1 in bits 4..2, bus-latch bits 7..5 in bits 7..5, and `port2_serial` in bits 1..0.
- R8: A write to index 3 stores the byte on `gpio_out`, and a read of index 3 returns the stored byte. After reset the register holds 8'hFF.
- R9: `cnt_latch` is high for exactly the one cycle after a write to index 3 that takes the stored bit 7 from 1 to 0. No other write raises it.
- R10: The bus latch takes the byte of every write and every read. A read of index 5, 6 or 7 returns the bus latch. A write to any index other than 3 changes nothing except the bus latch.
- R11: `rd_data` is registered. It changes only on the clock edge that samples `rd_en` and holds between reads. Reset clears `rd_data`, the bus latch, both flags and `cnt_latch`. `rd_en` and `wr_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| nmi_set | input | 1 | Sets the NMI flag |
| irq_set | input | 1 | Sets the IRQ flag |
| hpos | input | HCNT_W | Horizontal position counter |
| vpos | input | VCNT_W | Vertical position counter |
| disp_height | input | VCNT_W | Active display height in lines |
| poll_busy | input | 1 | Auto controller poll in progress |
| port2_serial | input | 2 | Port-2 serial data lines |
| gpio_out | output | 8 | General-purpose output register |
| cnt_latch | output | 1 | Counter capture pulse |

## Verification
The horizontal position is swept over every value of its 11-bit range. This separates the low end of the blank window from the high end, and shows whether the comparison at 2 and at 1096 is inclusive. The vertical position is swept against two display heights, which shows that the vertical comparison follows the `disp_height` input rather than a fixed constant.

The status words are read while the bus latch holds different values, so every bit filled from the latch is seen at both 0 and 1. The flag tests set a flag on its own, read it twice, and also raise the set strobe in the same cycle as the read; this separates "set wins" from "clear wins". The output-register writes cover all four transitions of bit 7, plus a write to another index, so an edge detector that fires on the wrong transition or on the wrong index is caught.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

    localparam int IDX_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_NMI   = 3'd0,
        IDX_IRQ   = 3'd1,
        IDX_BLANK = 3'd2,
        IDX_GPIO  = 3'd3,
        IDX_PORT2 = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic vblank;
        logic hblank;
        logic poll;
    } live_bits_t;

    // True inside the split blank window: at or below lo, or at or above hi.
    function automatic logic window_hit(int pos, int lo, int hi);
        return (pos <= lo) || (pos >= hi);
    endfunction

    // Bits under mask come from own; the remaining bits come from the bus latch.
    function automatic logic [7:0] merge_bus(logic [7:0] own, logic [7:0] mask,
                                             logic [7:0] latch);
        return (own & mask) | (latch & ~mask);
    endfunction

endpackage

// File: rtl/ivs_flag.sv
module ivs_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    assert_set_sticks_R3: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/ivs_gpio.sv
module ivs_gpio #(
    parameter logic [7:0] RST_VAL = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  logic [7:0] data_i,
    output logic [7:0] q_o,
    output logic       pulse_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o     <= RST_VAL;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= wr_i && q_o[7] && !data_i[7];
            if (wr_i)
                q_o <= data_i;
        end
    end

    assert_pulse_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> ($past(q_o[7]) && !q_o[7]));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/ivs_readmux.sv
module ivs_readmux
    import ivs_pkg::*;
#(
    parameter int         HCNT_W   = 11,
    parameter int         VCNT_W   = 9,
    parameter int         HB_LO    = 2,
    parameter int         HB_HI    = 1096,
    parameter logic [3:0] CHIP_VER = 4'h2
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        latch,
    input  logic              nmi_flag,
    input  logic              irq_flag,
    input  logic [HCNT_W-1:0] hpos,
    input  logic [VCNT_W-1:0] vpos,
    input  logic [VCNT_W-1:0] height,
    input  logic              poll,
    input  logic [1:0]        serial,
    input  logic [7:0]        gpio,
    output logic [7:0]        val
);

    live_bits_t live;

    always_comb begin
        live.vblank = (vpos >= height);
        live.hblank = window_hit(int'(hpos), HB_LO, HB_HI);
        live.poll   = poll;
    end

    always_comb begin
        case (idx)
            IDX_NMI:   val = merge_bus({nmi_flag, 3'b000, CHIP_VER}, 8'h8F, latch);
            IDX_IRQ:   val = merge_bus({irq_flag, 7'd0}, 8'h80, latch);
            IDX_BLANK: val = merge_bus({live.vblank, live.hblank, 5'd0, live.poll},
                                       8'hC1, latch);
            IDX_GPIO:  val = gpio;
            IDX_PORT2: val = merge_bus({3'b000, 3'b111, serial}, 8'h1F, latch);
            default:   val = latch;
        endcase
    end

endmodule

// File: rtl/irq_video_status.sv
module irq_video_status
    import ivs_pkg::*;
#(
    parameter int         HCNT_W   = 11,
    parameter int         VCNT_W   = 9,
    parameter int         HB_LO    = 2,
    parameter int         HB_HI    = 1096,
    parameter logic [3:0] CHIP_VER = 4'h2,
    parameter logic [7:0] GPIO_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              nmi_set,
    input  logic              irq_set,
    input  logic [HCNT_W-1:0] hpos,
    input  logic [VCNT_W-1:0] vpos,
    input  logic [VCNT_W-1:0] disp_height,
    input  logic              poll_busy,
    input  logic [1:0]        port2_serial,
    output logic [7:0]        gpio_out,
    output logic              cnt_latch
);

    localparam int NUM_FLAGS = 2;

    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [7:0]           bus_latch;
    logic [7:0]           rd_val;

    assign flag_set = {irq_set, nmi_set};

    // Flag g lives at register index g (NMI at 0, IRQ at 1).
    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        assign flag_clr[g] = rd_en && (addr == IDX_W'(g));
        ivs_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (flag_set[g]),
            .clr_i  (flag_clr[g]),
            .flag_o (flag_q[g])
        );
    end

    ivs_gpio #(.RST_VAL(GPIO_RST)) u_gpio (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_en && (addr == IDX_GPIO)),
        .data_i  (wr_data),
        .q_o     (gpio_out),
        .pulse_o (cnt_latch)
    );

    ivs_readmux #(
        .HCNT_W   (HCNT_W),
        .VCNT_W   (VCNT_W),
        .HB_LO    (HB_LO),
        .HB_HI    (HB_HI),
        .CHIP_VER (CHIP_VER)
    ) u_mux (
        .idx      (addr),
        .latch    (bus_latch),
        .nmi_flag (flag_q[0]),
        .irq_flag (flag_q[1]),
        .hpos     (hpos),
        .vpos     (vpos),
        .height   (disp_height),
        .poll     (poll_busy),
        .serial   (port2_serial),
        .gpio     (gpio_out),
        .val      (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= 8'h00;
            bus_latch <= 8'h00;
        end else if (wr_en) begin
            bus_latch <= wr_data;
        end else if (rd_en) begin
            rd_data   <= rd_val;
            bus_latch <= rd_val;
        end
    end

    assert_no_dual_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));

    assert_latch_write_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> (bus_latch == $past(wr_data)));

    assert_latch_read_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_en) && !$past(wr_en)) |-> (bus_latch == rd_data));

    assert_port2_ones_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_en) && !$past(wr_en) && ($past(addr) == IDX_PORT2))
        |-> (rd_data[4:2] == 3'b111));

endmodule

// File: tb/irq_video_status_test.sv
module irq_video_status_test;

    localparam int         CLK_PERIOD = 10;
    localparam logic [3:0] VER        = 4'h2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        nmi_set = 1'b0;
    logic        irq_set = 1'b0;
    logic [10:0] hpos = '0;
    logic [8:0]  vpos = '0;
    logic [8:0]  disp_height = 9'd224;
    logic        poll_busy = 1'b0;
    logic [1:0]  port2_serial = '0;
    logic [7:0]  gpio_out;
    logic        cnt_latch;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] mlatch = 8'h00;
    logic [7:0] got;
    logic [7:0] exp_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_video_status uut (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .nmi_set(nmi_set), .irq_set(irq_set),
        .hpos(hpos), .vpos(vpos), .disp_height(disp_height), .poll_busy(poll_busy),
        .port2_serial(port2_serial), .gpio_out(gpio_out), .cnt_latch(cnt_latch)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] idx, output logic [7:0] d);
        @(negedge clk);
        addr  = idx;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] v, input logic exp_pulse);
        @(negedge clk);
        addr    = idx;
        wr_data = v;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en  = 1'b0;
        mlatch = v;
        check("R9 pulse after write", {7'd0, cnt_latch}, {7'd0, exp_pulse});
        @(negedge clk);
        check("R9 pulse one cycle", {7'd0, cnt_latch}, 8'h00);
    endtask

    task automatic pulse_set(input logic is_irq);
        @(negedge clk);
        if (is_irq) irq_set = 1'b1; else nmi_set = 1'b1;
        @(negedge clk);
        irq_set = 1'b0;
        nmi_set = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 / R8 / R9 reset state
        check("R11 reset rd_data", rd_data, 8'h00);
        check("R8 reset gpio", gpio_out, 8'hFF);
        check("R9 reset pulse", {7'd0, cnt_latch}, 8'h00);

        // R10 open-bus read and latch capture of a write
        rd(3'd5, got); check("R10 unmapped after reset", got, 8'h00);
        wr(3'd6, 8'hA5, 1'b0);
        check("R10 write to other index leaves gpio", gpio_out, 8'hFF);
        rd(3'd7, got); check("R10 unmapped returns latch", got, 8'hA5);
        repeat (3) @(negedge clk);
        check("R11 rd_data holds", rd_data, 8'hA5);

        // R1 / R3 NMI
        rd(3'd0, got); exp_v = (mlatch & 8'h70) | {4'h0, VER};
        check("R1 nmi idle", got, exp_v); mlatch = exp_v;
        pulse_set(1'b0);
        rd(3'd0, got); exp_v = 8'h80 | (mlatch & 8'h70) | {4'h0, VER};
        check("R3 nmi set read", got, exp_v); mlatch = exp_v;
        rd(3'd0, got); exp_v = (mlatch & 8'h70) | {4'h0, VER};
        check("R3 nmi cleared", got, exp_v); mlatch = exp_v;

        // R2 / R3 IRQ, other flag untouched by NMI read
        wr(3'd5, 8'h5A, 1'b0);
        pulse_set(1'b1);
        rd(3'd0, got); exp_v = (mlatch & 8'h70) | {4'h0, VER};
        check("R3 nmi read keeps irq", got, exp_v); mlatch = exp_v;
        rd(3'd1, got); exp_v = 8'h80 | (mlatch & 8'h7F);
        check("R2 irq set read", got, exp_v); mlatch = exp_v;
        rd(3'd1, got); exp_v = mlatch & 8'h7F;
        check("R2 irq cleared", got, exp_v); mlatch = exp_v;

        // R3 set in same cycle as read
        @(negedge clk);
        addr = 3'd0; rd_en = 1'b1; nmi_set = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; nmi_set = 1'b0; got = rd_data;
        exp_v = (mlatch & 8'h70) | {4'h0, VER};
        check("R3 same-cycle read value", got, exp_v); mlatch = exp_v;
        rd(3'd0, got); exp_v = 8'h80 | (mlatch & 8'h70) | {4'h0, VER};
        check("R3 same-cycle set survives", got, exp_v); mlatch = exp_v;

        // R4 / R5 / R6 full horizontal sweep
        wr(3'd6, 8'h3E, 1'b0);
        disp_height = 9'd224;
        for (int h = 0; h < 2048; h++) begin
            hpos      = 11'(h);
            vpos      = 9'(h % 512);
            poll_busy = h[0];
            if (h % 300 == 7) wr(3'd6, 8'(h * 37), 1'b0);
            rd(3'd2, got);
            exp_v = {((h % 512) >= 224) ? 1'b1 : 1'b0,
                     (h <= 2 || h >= 1096) ? 1'b1 : 1'b0, 5'd0, h[0]}
                    | (mlatch & 8'h3E);
            check("R5 R4 R6 blank status", got, exp_v); mlatch = exp_v;
        end

        // R4 vertical sweep with a second height
        disp_height = 9'd239;
        hpos = 11'd500;
        for (int v = 0; v < 512; v++) begin
            vpos = 9'(v);
            poll_busy = 1'b0;
            rd(3'd2, got);
            exp_v = {(v >= 239) ? 1'b1 : 1'b0, 7'd0} | (mlatch & 8'h3E);
            check("R4 vblank height 239", got, exp_v); mlatch = exp_v;
        end

        // R7 port-2 status
        for (int s = 0; s < 4; s++) begin
            wr(3'd7, 8'(8'hE3 ^ (s * 8'h61)), 1'b0);
            port2_serial = 2'(s);
            rd(3'd4, got); exp_v = (mlatch & 8'hE0) | 8'h1C | 8'(s);
            check("R7 port2 status", got, exp_v); mlatch = exp_v;
        end

        // R8 / R9 output register transitions
        wr(3'd3, 8'h80, 1'b0);
        rd(3'd3, got); check("R8 gpio readback", got, 8'h80); mlatch = got;
        wr(3'd3, 8'h00, 1'b1);
        check("R8 gpio value", gpio_out, 8'h00);
        wr(3'd3, 8'h7F, 1'b0);
        wr(3'd3, 8'hFF, 1'b0);
        wr(3'd3, 8'hC3, 1'b0);
        wr(3'd3, 8'h7F, 1'b1);
        wr(3'd3, 8'hFF, 1'b0);
        wr(3'd4, 8'h00, 1'b0);
        check("R9 R10 other index no store", gpio_out, 8'hFF);
        rd(3'd3, got); check("R8 gpio final", got, 8'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule